// File: doc/BRIEF.md
# Randomized Subwarp Assignment Generator

This block decides, once per warp memory instruction, how the 32 threads of a warp are split into subwarps before their addresses reach the coalescing logic. It produces a vector of 32 five-bit subwarp ids, one per thread. A requester raises `req_valid` together with a policy code, a subwarp count and a shuffle flag. The block accepts the request, builds the assignment over a few cycles and then holds it on `out_ids` with `out_valid` high until the next request is accepted.

Four policies are available. One puts every thread into a single group. One splits the warp into equal contiguous runs. One keeps the requested group count but draws each group's size at random, biased so that the final group tends to be the largest. The last, which works with either split, randomly permutes which threads carry which id. Randomness comes from an internal 32-bit LFSR. The LFSR moves forward only when a value is consumed, so a reloaded seed followed by the same request sequence gives the same vectors.

Top module: `sw_assign_gen`

## Requirements
- R1: After reset `req_ready` is 1 and `out_valid` is 0. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `out_valid` is 0 in the cycle after acceptance. Once `out_valid` rises, it stays high and `out_ids` stays unchanged until the next acceptance.
- R2: Policy codes 0 and 3 give id 0 to every thread, whatever the count and shuffle inputs are.
- R3: Policy code 1 without shuffle gives thread t the id floor(t*C/32). C is the effective count: `req_count` with 0 read as 1 and values above 32 read as 32. The id of thread t sits in `out_ids[5t+4:5t]`.
- R4: Policy code 2 without shuffle gives ids that never decrease with the thread index. Thread 0 gets id 0, thread 31 gets id C-1, and every id from 0 to C-1 is held by at least one thread.
- R5: In policy code 2, each group except the last has a size of one plus the minimum of BIAS_DRAWS scaled draws over the room left. With the default of 3 draws and C=4, the final group averages more than 9 threads over many requests.
- R6: With shuffle set, policy codes 1 and 2 produce the same number of threads per id as the unshuffled rule (for code 1, exactly the run lengths of R3; for code 2, every id from 0 to C-1 is present and none is C or above). The placement of ids across threads varies from request to request.
- R7: `out_valid` first reads high after the (1+S+P)-th rising edge that follows the accepting edge. S is C-1 for code 2 and 0 otherwise. P is 31 when shuffle is set with code 1 or 2, and 0 otherwise.
- R8: Pulsing `seed_load` with a nonzero `seed_value` and then issuing a given request sequence always yields the same sequence of vectors.
- R9: A zero seed acts exactly like seed 0x1D872B41, which is also the value loaded by reset. The LFSR never holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Loads `seed_value` into the LFSR |
| seed_value | input | 32 | New LFSR seed; zero replaced by 0x1D872B41 |
| req_valid | input | 1 | Request for a new assignment |
| req_ready | output | 1 | Block can accept a request |
| req_mode | input | 2 | Policy: 0 single, 1 equal runs, 2 random sizes, 3 single |
| req_count | input | 6 | Requested subwarp count (clamped to 1..32) |
| req_shuffle | input | 1 | Randomly permute thread membership |
| out_valid | output | 1 | Assignment on `out_ids` is complete |
| out_ids | output | 160 | Thread t id in bits [5t+4:5t] |

## Verification
The equal-run policy is driven with counts 1, 2, 3, 4, 7, 16 and 32, plus the out-of-range values 0 and 40. These cases separate correct rounding of uneven runs and correct clamping from an off-by-one split. Random sizes are tried with counts 1, 2, 4, 5 and 32. Count 32 forces a single legal answer, and a 64-request batch at count 4 shows whether the bias actually moves mass into the last group. Shuffled runs compare per-id thread counts with the unshuffled rule, so a lost or duplicated id during a swap shows up, while a vector equal to the contiguous pattern in every trial reveals a dead permutation. Reloaded seeds, and a zero seed set against the default, tell reproducible LFSR use apart from stepping on idle cycles.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_FIXED  = 2'd1,
    MODE_RSIZE  = 2'd2,
    MODE_RSV    = 2'd3
  } sw_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_SIZE,
    ST_SHUF,
    ST_DONE
  } sw_state_e;
endpackage

// File: rtl/sw_lfsr.sv
module sw_lfsr #(
  parameter int W = 32,
  parameter logic [W-1:0] POLY = 'h0040_0007,
  parameter logic [W-1:0] DEFAULT_SEED = 'h1D87_2B41
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         advance,
  output logic [W-1:0] state
);
  logic [W-1:0] nxt;

  // W single-bit Galois steps per use, so each consumer sees a fresh word
  always_comb begin
    nxt = state;
    for (int s = 0; s < W; s++) begin
      nxt = {nxt[W-2:0], 1'b0} ^ (nxt[W-1] ? POLY : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= DEFAULT_SEED;
    end else if (load) begin
      state <= (seed == '0) ? DEFAULT_SEED : seed;
    end else if (advance) begin
      state <= nxt;
    end
  end

  p_nonzero_r9: assert property (@(posedge clk) disable iff (rst) state != '0)
    else $error("LFSR reached zero");
endmodule

// File: rtl/sw_draw.sv
module sw_draw #(
  parameter int SW    = 6,
  parameter int DRAWS = 1
)(
  input  logic [8*DRAWS-1:0] rnd,
  input  logic [SW-1:0]      span,
  output logic [SW-1:0]      val
);
  logic [SW-1:0] cand [DRAWS];

  // each byte scaled into [0, span-1] by multiply and shift
  generate
    for (genvar d = 0; d < DRAWS; d++) begin : g_draw
      logic [SW+7:0] prod;
      assign prod    = rnd[8*d +: 8] * span;
      assign cand[d] = SW'(prod >> 8);
    end
  endgenerate

  always_comb begin
    val = cand[0];
    for (int d = 1; d < DRAWS; d++) begin
      if (cand[d] < val) val = cand[d];
    end
  end
endmodule

// File: rtl/sw_assign_gen.sv
module sw_assign_gen
  import sw_pkg::*;
#(
  parameter int ID_W       = 5,
  parameter int LFSR_W     = 32,
  parameter int BIAS_DRAWS = 3,
  parameter logic [LFSR_W-1:0] LFSR_POLY    = 'h0040_0007,
  parameter logic [LFSR_W-1:0] DEFAULT_SEED = 'h1D87_2B41
)(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      seed_load,
  input  logic [LFSR_W-1:0]         seed_value,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [1:0]                req_mode,
  input  logic [ID_W:0]             req_count,
  input  logic                      req_shuffle,
  output logic                      out_valid,
  output logic [(1<<ID_W)*ID_W-1:0] out_ids
);
  localparam int NT = 1 << ID_W;
  localparam int CW = ID_W + 1;

  sw_state_e       state_q;
  sw_mode_e        mode_q;
  logic            shuf_q;
  logic [CW-1:0]   cnt_q;
  logic [ID_W-1:0] k_q;
  logic [CW-1:0]   pos_q;
  logic [ID_W-1:0] i_q;
  logic [ID_W-1:0] ids_q [NT];

  logic [LFSR_W-1:0] rnd;
  logic [CW-1:0]     size_span, size_draw, size_w;
  logic [CW-1:0]     swap_span, swap_j;
  logic [CW-1:0]     cnt_eff;
  logic              accept, advance;
  sw_state_e         tail_st;

  assign req_ready = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign accept    = req_valid && req_ready;
  assign out_valid = (state_q == ST_DONE);
  assign advance   = (state_q == ST_SIZE) || (state_q == ST_SHUF);
  assign tail_st   = shuf_q ? ST_SHUF : ST_DONE;

  always_comb begin
    if (req_count == '0)          cnt_eff = CW'(1);
    else if (int'(req_count) > NT) cnt_eff = CW'(NT);
    else                           cnt_eff = CW'(req_count);
  end

  // room for the current group: threads left minus one per later group
  assign size_span = CW'(NT - int'(pos_q) - (int'(cnt_q) - 1 - int'(k_q)));
  assign size_w    = CW'(int'(size_draw) + 1);
  assign swap_span = CW'(int'(i_q) + 1);

  sw_lfsr #(.W(LFSR_W), .POLY(LFSR_POLY), .DEFAULT_SEED(DEFAULT_SEED)) lfsr_i (
    .clk(clk), .rst(rst), .load(seed_load), .seed(seed_value),
    .advance(advance), .state(rnd)
  );

  sw_draw #(.SW(CW), .DRAWS(BIAS_DRAWS)) size_draw_i (
    .rnd(rnd[8*BIAS_DRAWS-1:0]), .span(size_span), .val(size_draw)
  );

  sw_draw #(.SW(CW), .DRAWS(1)) swap_draw_i (
    .rnd(rnd[LFSR_W-1 -: 8]), .span(swap_span), .val(swap_j)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_SINGLE;
      shuf_q  <= 1'b0;
      cnt_q   <= CW'(1);
      k_q     <= '0;
      pos_q   <= '0;
      i_q     <= '0;
      for (int t = 0; t < NT; t++) ids_q[t] <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            mode_q  <= sw_mode_e'(req_mode);
            shuf_q  <= req_shuffle;
            cnt_q   <= cnt_eff;
            state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          for (int t = 0; t < NT; t++) begin
            case (mode_q)
              MODE_FIXED: ids_q[t] <= ID_W'((t * int'(cnt_q)) >> ID_W);
              MODE_RSIZE: ids_q[t] <= ID_W'(int'(cnt_q) - 1);
              default:    ids_q[t] <= '0;
            endcase
          end
          k_q   <= '0;
          pos_q <= '0;
          i_q   <= ID_W'(NT - 1);
          case (mode_q)
            MODE_FIXED: state_q <= tail_st;
            MODE_RSIZE: state_q <= (cnt_q == CW'(1)) ? tail_st : ST_SIZE;
            default:    state_q <= ST_DONE;
          endcase
        end
        ST_SIZE: begin
          for (int t = 0; t < NT; t++) begin
            if (t >= int'(pos_q) && t < int'(pos_q) + int'(size_w)) ids_q[t] <= k_q;
          end
          pos_q <= CW'(int'(pos_q) + int'(size_w));
          k_q   <= ID_W'(int'(k_q) + 1);
          if (int'(k_q) == int'(cnt_q) - 2) state_q <= tail_st;
        end
        ST_SHUF: begin
          ids_q[i_q]                <= ids_q[swap_j[ID_W-1:0]];
          ids_q[swap_j[ID_W-1:0]]   <= ids_q[i_q];
          i_q <= ID_W'(int'(i_q) - 1);
          if (i_q == ID_W'(1)) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int t = 0; t < NT; t++) out_ids[t*ID_W +: ID_W] = ids_q[t];
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !accept) |=> (out_valid && $stable(out_ids)))
    else $error("result changed while held");

  p_drop_r1: assert property (@(posedge clk) disable iff (rst)
    accept |=> !out_valid)
    else $error("valid not cleared after acceptance");

  p_single_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (mode_q == MODE_SINGLE || mode_q == MODE_RSV)) |-> (out_ids == '0))
    else $error("single policy produced nonzero id");

  p_fit_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SIZE) |->
      (int'(pos_q) + int'(size_w) + int'(cnt_q) - 1 - int'(k_q) <= NT))
    else $error("group size leaves no room for later groups");

  p_swap_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SHUF) |-> (int'(swap_j) <= int'(i_q)))
    else $error("swap partner out of range");
endmodule

// File: tb/sw_assign_gen_tb.sv
module sw_assign_gen_tb_top;
  localparam int NT = 32;
  localparam int IW = 5;
  localparam logic [31:0] DEF_SEED = 32'h1D87_2B41;

  typedef struct {
    int  mode;
    int  cnt;
    bit  shuf;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic seed_load = 1'b0;
  logic [31:0] seed_value = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_mode = '0;
  logic [5:0] req_count = '0;
  logic req_shuffle = 1'b0;
  logic out_valid;
  logic [NT*IW-1:0] out_ids;

  always #2 clk = ~clk;

  sw_assign_gen dut_i (
    .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
    .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
    .req_count(req_count), .req_shuffle(req_shuffle),
    .out_valid(out_valid), .out_ids(out_ids)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  item_t exp_q[$];
  logic [NT*IW-1:0] last_vec;
  int last_final;
  bit prev_v = 0;

  task automatic chk(input bit ok, input string tag, input logic [NT*IW-1:0] act,
                     input logic [NT*IW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int clampc(input int c);
    if (c == 0) return 1;
    if (c > NT) return NT;
    return c;
  endfunction

  function automatic logic [NT*IW-1:0] runs_vec(input int c);
    logic [NT*IW-1:0] v;
    for (int t = 0; t < NT; t++) v[t*IW +: IW] = IW'((t * c) / NT);
    return v;
  endfunction

  task automatic check_item(input item_t it);
    int ids[NT];
    int hist[NT];
    bit ok;
    logic [NT*IW-1:0] ev;
    for (int t = 0; t < NT; t++) hist[t] = 0;
    for (int t = 0; t < NT; t++) begin
      ids[t] = int'(out_ids[t*IW +: IW]);
      hist[ids[t]]++;
    end
    ev = runs_vec(it.cnt);
    if (it.mode == 0 || it.mode == 3) begin
      chk(out_ids == '0, "R2 single policy all zero", out_ids, '0);
    end else if (it.mode == 1) begin
      if (!it.shuf) chk(out_ids == ev, "R3 equal runs", out_ids, ev);
      else begin
        ok = 1;
        for (int c = 0; c < it.cnt; c++) begin
          int run = 0;
          for (int t = 0; t < NT; t++) if ((t * it.cnt) / NT == c) run++;
          if (hist[c] != run) ok = 0;
        end
        chk(ok, "R6 shuffled runs keep sizes", out_ids, ev);
      end
    end else begin
      ok = 1;
      for (int t = 0; t < NT; t++) if (ids[t] >= it.cnt) ok = 0;
      for (int c = 0; c < it.cnt; c++) if (hist[c] == 0) ok = 0;
      if (!it.shuf) begin
        for (int t = 1; t < NT; t++) if (ids[t] < ids[t-1]) ok = 0;
        if (ids[0] != 0 || ids[NT-1] != it.cnt - 1) ok = 0;
        chk(ok, "R4 random sizes contiguous and complete", out_ids, ev);
      end else begin
        chk(ok, "R6 shuffled random sizes complete", out_ids, ev);
      end
    end
    last_final = hist[it.cnt - 1];
    last_vec   = out_ids;
  endtask

  // monitor: pops the expected item whenever a new result appears
  always @(negedge clk) begin
    if (rst) prev_v = 0;
    else begin
      if (out_valid && !prev_v) begin
        if (exp_q.size() == 0) chk(0, "R1 result without request", out_ids, '0);
        else check_item(exp_q.pop_front());
      end
      prev_v = out_valid;
    end
  end

  task automatic issue(input int mode, input int cnt_raw, input bit shuf);
    item_t it;
    int c, s, p, lat;
    c = clampc(cnt_raw);
    it.mode = mode; it.cnt = c; it.shuf = shuf;
    s = (mode == 2 && c > 1) ? c - 1 : 0;
    p = ((mode == 1 || mode == 2) && shuf) ? 31 : 0;
    exp_q.push_back(it);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_mode = 2'(mode); req_count = 6'(cnt_raw); req_shuffle = shuf;
    @(negedge clk);
    req_valid = 0;
    chk(!out_valid, "R1 valid low after accept", {159'd0, out_valid}, '0);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!out_valid && lat < 300);
    chk(lat == 1 + s + p, "R7 latency", (NT*IW)'(lat), (NT*IW)'(1 + s + p));
    @(negedge clk);
  endtask

  task automatic load_seed(input logic [31:0] v);
    @(negedge clk);
    seed_load = 1; seed_value = v;
    @(negedge clk);
    seed_load = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NT*IW-1:0] rec[3];
    logic [NT*IW-1:0] held, contig, va;
    int sum_final;
    bit differs;

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready && !out_valid, "R1 reset state", {158'd0, req_ready, out_valid}, {158'd0, 2'b10});

    // R2: single policy ignores count and shuffle
    issue(0, 5, 1);
    issue(3, 17, 0);

    // R3: equal runs, including clamped counts
    issue(1, 1, 0);
    issue(1, 2, 0);
    issue(1, 3, 0);
    issue(1, 4, 0);
    issue(1, 7, 0);
    issue(1, 16, 0);
    issue(1, 32, 0);
    issue(1, 0, 0);
    issue(1, 40, 0);

    // R1: result held while no new request
    held = out_ids;
    repeat (6) @(negedge clk);
    chk(out_valid && out_ids == held, "R1 result held", out_ids, held);

    // R4: random sizes
    issue(2, 1, 0);
    issue(2, 2, 0);
    issue(2, 4, 0);
    issue(2, 5, 0);
    issue(2, 32, 0);
    chk(out_ids == runs_vec(32), "R4 count 32 forces identity", out_ids, runs_vec(32));

    // R5: bias toward a large final group
    sum_final = 0;
    for (int n = 0; n < 64; n++) begin
      issue(2, 4, 0);
      sum_final += last_final;
    end
    chk(sum_final > 64 * 9, "R5 final group mean above 9",
        (NT*IW)'(sum_final), (NT*IW)'(64 * 9));

    // R6: shuffle keeps sizes and moves placement
    contig = runs_vec(2);
    differs = 0;
    for (int n = 0; n < 8; n++) begin
      issue(1, 2, 1);
      if (last_vec != contig) differs = 1;
    end
    chk(differs, "R6 placement varies", last_vec, contig);
    for (int n = 0; n < 4; n++) issue(2, 6, 1);

    // R8: reproducible after reseeding
    load_seed(32'h0000_1234);
    for (int n = 0; n < 3; n++) begin
      issue(2, 5, 1);
      rec[n] = last_vec;
    end
    load_seed(32'h0000_1234);
    for (int n = 0; n < 3; n++) begin
      issue(2, 5, 1);
      chk(last_vec == rec[n], "R8 same seed same vectors", last_vec, rec[n]);
    end

    // R9: zero seed equals the default seed
    load_seed(32'h0);
    issue(2, 7, 1);
    va = last_vec;
    load_seed(DEF_SEED);
    issue(2, 7, 1);
    chk(last_vec == va, "R9 zero seed replaced by default", va, last_vec);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule